// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Rounding

This unit multiplies two signed 16-bit fractions and then adds the product to a 36-bit accumulator operand or subtracts it from that operand. The accumulator has 4 guard bits above a 32-bit fraction. The sum is rounded to a 16-bit precision boundary, and the result is returned with its low word cleared. A narrow destination mode accepts a 16-bit addend instead of the accumulator. In that mode the caller takes the rounded high word from a separate output.

Rounding is chosen per operation. The first method rounds half to even, which removes statistical bias. The second adds one half and truncates. The unit does not saturate: a sum that overflows wraps modulo 2^36 and is passed on unchanged, so that a later limiter can deal with it. The unit is one registered stage, and every operation takes one clock.

Top module: `fmac_round`

## Requirements
- R1: The product is the signed integer product of `src_a` and `src_b` shifted left by one bit and sign-extended to 36 bits. For example, 0x0280 × 0x0200 gives 0x0_000A_0000, and 0x8000 × 0x8000 gives +1.0 = 0x0_8000_0000.
- R2: When `sub_en` is 0 the product is added to the addend. When `sub_en` is 1 the product is subtracted from the addend.
- R3: When `dst_narrow` is 1 the addend is built from `dst_word`: bits 35:32 are copies of its bit 15, bits 31:16 are `dst_word`, and bits 15:0 are zero. In this mode `acc_in` is ignored. When `dst_narrow` is 0 the addend is `acc_in`, and `dst_word` is ignored.
- R4: When `round_tc` is 1 the unit adds 0x8000 to the 36-bit sum and then clears bits 15:0.
- R5: When `round_tc` is 0 the unit rounds half to even. It rounds up when sum bits 15:0 exceed 0x8000 and rounds down when they are below 0x8000. On an exact 0x8000 it rounds up only when sum bit 16 is 1.
- R6: Bits 15:0 of `result` are always zero.
- R7: `result_hi` equals bits 31:16 of `result`.
- R8: All arithmetic wraps modulo 2^36 with no saturation. For example, 0x7_FFFF_8000 with a zero product and `round_tc`=1 gives 0x8_0000_0000.
- R9: `out_valid` follows `in_valid` one clock later. `result` and `result_hi` change only in the clock after `in_valid` is high, and they hold their values otherwise.
- R10: While `rst_n` is low, `result`, `result_hi` and `out_valid` are cleared. The rounding mode input selects half-to-even when it is 0.
- R11: Operands 0x0280 and 0x0200 added to 0x0_0000_8000 give 0x0_000A_0000 with half-to-even rounding and 0x0_000B_0000 with add-half rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 16 | First fractional operand |
| src_b | input | 16 | Second fractional operand |
| acc_in | input | 36 | Wide addend |
| dst_word | input | 16 | Narrow addend |
| dst_narrow | input | 1 | Selects the narrow addend |
| sub_en | input | 1 | Subtract the product instead of adding it |
| round_tc | input | 1 | 1: add half; 0: half to even |
| out_valid | output | 1 | Result strobe |
| result | output | 36 | Rounded result, low word zero |
| result_hi | output | 16 | Rounded bits 31:16 |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that the operand and mode inputs are known whenever `in_valid` is high. The bench keeps `in_valid` at 0 during reset and drives every input on the falling edge, so each value is settled before the rising edge. The sweeps combine extreme operands with accumulator values that hit wrap-around and exact rounding ties. They also change the ignored addend between operations, and they hold `in_valid` low across input changes to confirm that the result does not move.

// File: rtl/fmac_round.sv
module fmac_round #(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [OP_W-1:0]             src_a,
  input  logic [OP_W-1:0]             src_b,
  input  logic [GUARD_W+2*OP_W-1:0]   acc_in,
  input  logic [OP_W-1:0]             dst_word,
  input  logic                        dst_narrow,
  input  logic                        sub_en,
  input  logic                        round_tc,
  output logic                        out_valid,
  output logic [GUARD_W+2*OP_W-1:0]   result,
  output logic [OP_W-1:0]             result_hi
);
  localparam int ACC_W = GUARD_W + 2*OP_W;
  localparam int UP_W  = ACC_W - OP_W;
  localparam logic [OP_W-1:0] HALF = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [2*OP_W-1:0] iprod;
  logic [ACC_W-1:0] prod_ext, addend, sum, rounded;
  logic [OP_W-1:0]  low;
  logic [UP_W-1:0]  upper;
  logic             up_cv, round_up;

  assign iprod    = $signed(src_a) * $signed(src_b);
  assign prod_ext = {{GUARD_W{iprod[2*OP_W-1]}}, iprod} << 1;
  assign addend   = dst_narrow ? {{GUARD_W{dst_word[OP_W-1]}}, dst_word, {OP_W{1'b0}}} : acc_in;
  assign sum      = sub_en ? addend - prod_ext : addend + prod_ext;

  assign low      = sum[OP_W-1:0];
  assign up_cv    = (low > HALF) || ((low == HALF) && sum[OP_W]);
  assign round_up = round_tc ? low[OP_W-1] : up_cv;
  assign upper    = sum[ACC_W-1:OP_W] + {{(UP_W-1){1'b0}}, round_up};
  assign rounded  = {upper, {OP_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      result_hi <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= rounded;
        result_hi <= rounded[2*OP_W-1:OP_W];
      end
    end
  end
endmodule

module fmac_round_chk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [ACC_W-1:0] result,
  input logic [OP_W-1:0]  result_hi
);
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(result_hi)));
  p_hi_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result_hi == result[2*OP_W-1:OP_W]));
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0 && result_hi == '0));
endmodule

bind fmac_round fmac_round_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .result_hi(result_hi)
);

// File: tb/fmac_round_tb_top.sv
module fmac_round_tb_top;
  localparam longint MASK = 64'h0000_000F_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] src_a = '0, src_b = '0, dst_word = '0;
  logic [35:0] acc_in = '0;
  logic        dst_narrow = 1'b0, sub_en = 1'b0, round_tc = 1'b0;
  logic        out_valid;
  logic [35:0] result;
  logic [15:0] result_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fmac_round dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .dst_word(dst_word), .dst_narrow(dst_narrow), .sub_en(sub_en),
    .round_tc(round_tc), .out_valid(out_valid), .result(result), .result_hi(result_hi)
  );

  function automatic longint model(logic [15:0] a, logic [15:0] b, logic [35:0] acc,
                                   logic [15:0] dw, bit narrow, bit sub, bit tc);
    longint p, ad, s, lo, up;
    p  = longint'($signed(a)) * longint'($signed(b)) * 2;
    ad = narrow ? longint'($signed(dw)) * 65536 : longint'(acc);
    s  = (sub ? ad - p : ad + p) & MASK;
    lo = s & 64'hFFFF;
    if (tc) up = (lo >= 64'h8000) ? 1 : 0;
    else    up = (lo > 64'h8000 || (lo == 64'h8000 && s[16])) ? 1 : 0;
    return (((s >> 16) + up) << 16) & MASK;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic run_op(string tag, logic [15:0] a, logic [15:0] b, logic [35:0] acc,
                        logic [15:0] dw, bit narrow, bit sub, bit tc);
    longint e;
    src_a = a; src_b = b; acc_in = acc; dst_word = dw;
    dst_narrow = narrow; sub_en = sub; round_tc = tc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = model(a, b, acc, dw, narrow, sub, tc);
    check(tag, longint'(result), e);
    check("R6", longint'(result[15:0]), 0);
    check("R7", longint'(result_hi), (e >> 16) & 64'hFFFF);
    check("R9", longint'(out_valid), 1);
  endtask

  initial begin
    logic [15:0] ops [9] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
                             16'h0280, 16'h0200, 16'h4000, 16'hC000};
    logic [35:0] accs [4] = '{36'h0_0000_8000, 36'h7_FFFF_8000, 36'h8_0000_0000, 36'h0_0001_7FFF};
    logic [15:0] dws [3] = '{16'h8000, 16'h7FFF, 16'h0001};
    logic [35:0] hold_r;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", longint'(result), 0);
    check("R10", longint'(result_hi), 0);
    check("R10", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 worked vector, both rounding modes
    run_op("R11", 16'h0280, 16'h0200, 36'h0_0000_8000, 16'h0, 0, 0, 0);
    check("R11", longint'(result), 64'h0_000A_0000);
    run_op("R11", 16'h0280, 16'h0200, 36'h0_0000_8000, 16'h0, 0, 0, 1);
    check("R11", longint'(result), 64'h0_000B_0000);

    // R1 product scaling and the -1 x -1 corner
    run_op("R1", 16'h0280, 16'h0200, 36'h0, 16'h0, 0, 0, 0);
    check("R1", longint'(result), 64'h0_000A_0000);
    run_op("R1", 16'h8000, 16'h8000, 36'h0, 16'h0, 0, 0, 0);
    check("R1", longint'(result), 64'h0_8000_0000);

    // R8 wrap past guard bits
    run_op("R8", 16'h0, 16'h0, 36'h7_FFFF_8000, 16'h0, 0, 0, 1);
    check("R8", longint'(result), 64'h8_0000_0000);
    run_op("R8", 16'h0, 16'h0, 36'hF_FFFF_8000, 16'h0, 0, 0, 1);
    check("R8", longint'(result), 0);

    // R2 R3 R4 R5 sweep: operands x addends x modes
    for (int ia = 0; ia < 9; ia++)
      for (int ib = 0; ib < 9; ib++)
        for (int ic = 0; ic < 4; ic++)
          for (int m = 0; m < 8; m++) begin
            bit nar = m[2];
            run_op(m[0] ? "R4" : (nar ? "R3" : "R2"), ops[ia], ops[ib],
                   nar ? {ops[ib], ops[ia], 4'h5} : accs[ic],
                   nar ? dws[ic % 3] : ops[ia] ^ 16'h5A5A, nar, m[1], m[0]);
          end

    // R5 tie neighbourhood, odd and even bit 16, both modes
    for (int up = 1; up <= 2; up++)
      for (int lo = 16'h7FF0; lo <= 16'h8010; lo++)
        for (int tc = 0; tc < 2; tc++)
          run_op(tc ? "R4" : "R5", 16'h0, 16'h0, {20'(up), 16'(lo)}, 16'h0, 0, 0, tc[0]);
    run_op("R5", 16'h0, 16'h0, 36'h0_0001_8000, 16'h0, 0, 0, 0);
    check("R5", longint'(result), 64'h0_0002_0000);
    run_op("R5", 16'h0, 16'h0, 36'h0_0002_8000, 16'h0, 0, 0, 0);
    check("R5", longint'(result), 64'h0_0002_0000);

    // R9 hold while idle, inputs changing
    hold_r = result;
    src_a = 16'h7FFF; src_b = 16'h7FFF; acc_in = 36'h1_2345_6789; round_tc = 1'b1;
    repeat (3) begin
      @(negedge clk);
      acc_in = acc_in + 36'h1_0000;
      check("R9", longint'(result), longint'(hold_r));
      check("R9", longint'(out_valid), 0);
    end

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule